// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive descriptor ring for an Ethernet-style MAC. A ring of 32 two-word descriptors lives in local flops. The host fills in each descriptor, sets its ownership flag to hand it to the engine, and writes a limit index that says how far into the ring the engine may go. The receive datapath reports each finished frame on a one-cycle frame-done strobe, together with its byte count and an error flag.

For each finished frame, the engine checks the descriptor at its ring pointer. If that slot lies inside the host's limit and the engine owns it, the engine writes the length and error result into the descriptor and clears the ownership flag. It then steps the pointer and raises a sticky receive-done status. If the slot is not usable, the frame is dropped and an overflow counter counts it. The engine does not move payload bytes.

Host map: when `host_addr` bit 6 is 0, the address selects descriptor word `host_addr[5:1]`, with `host_addr[0]` = 0 for the command word and 1 for the extension word. When bit 6 is 1, `host_addr[2:0]` selects a register: 0 control (bit 0 enable), 1 limit, 2 status (bit 0 done, bit 1 overflow, write 1 to clear), 3 interrupt mask (bit 0 and bit 1 mask the matching status bits), 4 overflow count (read only).

Top module: `rx_desc_ring`

## Requirements
- R1: A synchronous reset sets the following values. Ring pointer: 0. Status: 0. Control: 0. Overflow count: 0. Limit: 32. Mask: 3. Every descriptor word: 0. Output `irq`: low.
- R2: The engine writes back a descriptor it owns, which is one whose command word has bit 31 set. The new command word has bit 31 at 0, bits 30:16 holding the frame byte count (CRC included, values up to 2048), and bits 15:0 unchanged.
- R3: Write-back sets bit 30 of the extension word to the frame error flag and leaves the other extension bits unchanged.
- R4: Each write-back advances the ring pointer by one, and the pointer wraps from 31 to 0.
- R5: A descriptor with index i is usable only when i is less than the limit; a limit of 32 or more grants the whole ring. A frame that arrives while the pointer is at or past the limit is dropped as an overflow.
- R6: A frame whose descriptor is unusable (not owned or past the limit) leaves the descriptor and the pointer unchanged. It increments the overflow count and sets status bit 1.
- R7: Status bit 0 is set by every write-back and stays set until the host writes 1 to it; writing 0 has no effect. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq` is high whenever a status bit is set and its mask bit is 0.
- R9: While control bit 0 is 0, frame-done strobes change no descriptor, pointer, status or count.
- R10: The host can write and read back every descriptor word, the control register, the limit and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 7 | Host word address (descriptor or register) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` (combinational) |
| frm_done | input | 1 | One-cycle strobe: a frame has finished |
| frm_len | input | 12 | Byte count of the finished frame, CRC included |
| frm_err | input | 1 | The finished frame had an error |
| irq | output | 1 | Receive interrupt |

## Verification
Frames are sent in several situations: to owned slots with and without errors, to a slot the host still holds, to a slot beyond a reduced limit, and across the ring end. Each case is judged by which descriptor changes and by the overflow count, so a pointer that moves wrongly shows up as a write to the wrong slot. The length is tried from a small value up to 2048, so a truncated field is caught. Status is cleared with 0 and with 1, and once in the same cycle as a set, which separates a correct write-1-to-clear from a plain write. A mid-run reset followed by a frame shows whether the pointer really returns to slot 0.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int WORD_W  = 32;
    localparam int OWN_BIT = 31;
    localparam int ERR_BIT = 30;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_LIMIT = 3'd1,
        SEL_STAT  = 3'd2,
        SEL_MASK  = 3'd3,
        SEL_OVF   = 3'd4
    } reg_sel_e;

    // bit 1: overflow event, bit 0: frame written back
    typedef struct packed {
        logic ovf;
        logic done;
    } rx_stat_t;

    // Command word after completion: ownership cleared, length in the upper half.
    function automatic logic [WORD_W-1:0] close_cmd(input logic [15:0] keep,
                                                    input logic [14:0] len);
        return {1'b0, len, keep};
    endfunction

    function automatic logic [WORD_W-1:0] mark_err(input logic [WORD_W-1:0] old,
                                                   input logic err);
        logic [WORD_W-1:0] r;
        r = old;
        r[ERR_BIT] = err;
        return r;
    endfunction

endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
    import rxr_pkg::*;
#(
    parameter int NDESC = 32,
    parameter int IDX_W = $clog2(NDESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic              host_hi,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rd_cmd,
    output logic [WORD_W-1:0] host_rd_hi,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  eng_idx,
    input  logic [WORD_W-1:0] eng_cmd,
    input  logic [WORD_W-1:0] eng_hi,
    output logic              ptr_own,
    output logic [15:0]       ptr_keep,
    output logic [WORD_W-1:0] ptr_hi
);

    logic [WORD_W-1:0] cmd_q [NDESC];
    logic [WORD_W-1:0] hi_q  [NDESC];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NDESC; i++) begin
            if (rst) begin
                cmd_q[i] <= '0;
                hi_q[i]  <= '0;
            end else if (eng_we && eng_idx == IDX_W'(i)) begin
                cmd_q[i] <= eng_cmd;
                hi_q[i]  <= eng_hi;
            end else if (host_we && host_idx == IDX_W'(i)) begin
                if (host_hi) hi_q[i]  <= host_wdata;
                else         cmd_q[i] <= host_wdata;
            end
        end
    end

    assign host_rd_cmd = cmd_q[host_idx];
    assign host_rd_hi  = hi_q[host_idx];
    assign ptr_own     = cmd_q[eng_idx][OWN_BIT];
    assign ptr_keep    = cmd_q[eng_idx][15:0];
    assign ptr_hi      = hi_q[eng_idx];

    // R2: a written-back slot is returned to the host
    p_own_cleared_r2: assert property (@(posedge clk) disable iff (rst)
        eng_we |=> !cmd_q[$past(eng_idx)][OWN_BIT]);

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int NDESC  = 32,
    parameter int LEN_W  = 12,
    parameter int IDX_W  = $clog2(NDESC),
    parameter int KICK_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [KICK_W-1:0] limit,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    input  logic              ptr_own,
    input  logic [15:0]       ptr_keep,
    input  logic [WORD_W-1:0] ptr_hi,
    output logic [IDX_W-1:0]  ptr,
    output logic              eng_we,
    output logic [WORD_W-1:0] eng_cmd,
    output logic [WORD_W-1:0] eng_hi,
    output logic              took,
    output logic              dropped
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NDESC - 1);

    logic granted;
    logic [IDX_W-1:0] ptr_q;

    assign granted = (int'(limit) >= NDESC) || ({1'b0, ptr_q} < limit);
    assign took    = frm_done && enable && granted && ptr_own;
    assign dropped = frm_done && enable && !(granted && ptr_own);

    assign eng_we  = took;
    assign eng_cmd = close_cmd(ptr_keep, 15'(frm_len));
    assign eng_hi  = mark_err(ptr_hi, frm_err);

    always_ff @(posedge clk) begin
        if (rst)       ptr_q <= '0;
        else if (took) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign ptr = ptr_q;

    // R4: one step per write-back, wrapping at the ring end
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        took |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

    // R6: no write-back, no movement
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !took |=> $stable(ptr_q));

endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int NDESC  = 32,
    parameter int OVF_W  = 16,
    parameter int KICK_W = $clog2(NDESC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        sel,
    input  logic [KICK_W-1:0] wdata,
    input  logic              took,
    input  logic              dropped,
    output logic              enable,
    output logic [KICK_W-1:0] limit,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);

    logic              en_q;
    logic [KICK_W-1:0] limit_q;
    rx_stat_t          stat_q;
    logic [1:0]        mask_q;
    logic [OVF_W-1:0]  ovf_q;
    logic [1:0]        clr;

    assign clr = (wr_en && reg_sel_e'(sel) == SEL_STAT) ? wdata[1:0] : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            limit_q <= KICK_W'(NDESC);
            stat_q  <= '0;
            mask_q  <= 2'b11;
            ovf_q   <= '0;
        end else begin
            if (wr_en && reg_sel_e'(sel) == SEL_CTRL)  en_q    <= wdata[0];
            if (wr_en && reg_sel_e'(sel) == SEL_LIMIT) limit_q <= wdata;
            if (wr_en && reg_sel_e'(sel) == SEL_MASK)  mask_q  <= wdata[1:0];
            stat_q.done <= took    | (stat_q.done & ~clr[0]);
            stat_q.ovf  <= dropped | (stat_q.ovf  & ~clr[1]);
            if (dropped) ovf_q <= ovf_q + 1'b1;
        end
    end

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_CTRL:  rdata = {{(WORD_W-1){1'b0}}, en_q};
            SEL_LIMIT: rdata = WORD_W'(limit_q);
            SEL_STAT:  rdata = {{(WORD_W-2){1'b0}}, stat_q};
            SEL_MASK:  rdata = {{(WORD_W-2){1'b0}}, mask_q};
            SEL_OVF:   rdata = WORD_W'(ovf_q);
            default:   rdata = '0;
        endcase
    end

    assign enable = en_q;
    assign limit  = limit_q;
    assign irq    = |(stat_q & ~mask_q);

    // R7: a write-back always leaves the done bit set
    p_done_set_r7: assert property (@(posedge clk) disable iff (rst)
        took |=> stat_q.done);

    // R7: a clear without a concurrent set removes the bit
    p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr[0] && !took) |=> !stat_q.done);

    // R6: every drop counts once
    p_ovf_count_r6: assert property (@(posedge clk) disable iff (rst)
        dropped |=> ovf_q == $past(ovf_q) + 1'b1);

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rxr_pkg::*;
#(
    parameter int NDESC = 32,
    parameter int LEN_W = 12,
    parameter int OVF_W = 16,
    localparam int IDX_W  = $clog2(NDESC),
    localparam int KICK_W = IDX_W + 1,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    output logic              irq
);

    logic              is_reg;
    logic [IDX_W-1:0]  host_idx;
    logic              host_hi;
    logic [WORD_W-1:0] rd_cmd, rd_hi, reg_rdata;
    logic              ptr_own;
    logic [15:0]       ptr_keep;
    logic [WORD_W-1:0] ptr_hi;
    logic [IDX_W-1:0]  ptr;
    logic              eng_we, took, dropped, enable;
    logic [WORD_W-1:0] eng_cmd, eng_hi;
    logic [KICK_W-1:0] limit;

    assign is_reg   = host_addr[ADDR_W-1];
    assign host_idx = host_addr[IDX_W:1];
    assign host_hi  = host_addr[0];

    rxr_desc_store #(.NDESC(NDESC), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .host_we(host_wr && !is_reg), .host_idx(host_idx), .host_hi(host_hi),
        .host_wdata(host_wdata), .host_rd_cmd(rd_cmd), .host_rd_hi(rd_hi),
        .eng_we(eng_we), .eng_idx(ptr), .eng_cmd(eng_cmd), .eng_hi(eng_hi),
        .ptr_own(ptr_own), .ptr_keep(ptr_keep), .ptr_hi(ptr_hi)
    );

    rxr_engine #(.NDESC(NDESC), .LEN_W(LEN_W), .IDX_W(IDX_W), .KICK_W(KICK_W)) u_engine (
        .clk(clk), .rst(rst), .enable(enable), .limit(limit),
        .frm_done(frm_done), .frm_len(frm_len), .frm_err(frm_err),
        .ptr_own(ptr_own), .ptr_keep(ptr_keep), .ptr_hi(ptr_hi),
        .ptr(ptr), .eng_we(eng_we), .eng_cmd(eng_cmd), .eng_hi(eng_hi),
        .took(took), .dropped(dropped)
    );

    rxr_regs #(.NDESC(NDESC), .OVF_W(OVF_W), .KICK_W(KICK_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(host_wr && is_reg), .sel(host_addr[2:0]),
        .wdata(host_wdata[KICK_W-1:0]),
        .took(took), .dropped(dropped),
        .enable(enable), .limit(limit), .rdata(reg_rdata), .irq(irq)
    );

    assign host_rdata = is_reg ? reg_rdata : (host_hi ? rd_hi : rd_cmd);

    // R9: a disabled engine neither writes back nor drops
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!took && !dropped));

    // R6: write-back only into a slot the store reports as engine-owned
    p_only_owned_r6: assert property (@(posedge clk) disable iff (rst)
        took |-> ptr_own);

    // R2: an owned, granted slot is never dropped
    p_no_false_drop_r2: assert property (@(posedge clk) disable iff (rst)
        dropped |-> !took);

endmodule

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        frm_done = 1'b0;
    logic [11:0] frm_len = '0;
    logic        frm_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    localparam logic [6:0] A_CTRL = 7'd64, A_LIMIT = 7'd65, A_STAT = 7'd66,
                           A_MASK = 7'd67, A_OVF = 7'd68;
    localparam logic [31:0] OWNED = 32'h8000_0800, HI_INIT = 32'h4000_1234;

    always #2 clk = ~clk;

    rx_desc_ring dut_i (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .frm_done(frm_done), .frm_len(frm_len), .frm_err(frm_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic chk_rd(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic frame(input logic [11:0] len, input logic err);
        @(negedge clk);
        frm_done = 1'b1; frm_len = len; frm_err = err;
        @(negedge clk);
        frm_done = 1'b0;
    endtask

    function automatic logic [6:0] cmd_a(input int i); return 7'(2 * i); endfunction
    function automatic logic [6:0] hi_a(input int i);  return 7'(2 * i + 1); endfunction
    function automatic logic [31:0] done_cmd(input int len);
        return {1'b0, 15'(len), 16'h0800};
    endfunction

    task automatic t_reset;
        chk_rd("R1 status", A_STAT, 0);
        chk_rd("R1 control", A_CTRL, 0);
        chk_rd("R1 limit", A_LIMIT, 32);
        chk_rd("R1 mask", A_MASK, 3);
        chk_rd("R1 overflow", A_OVF, 0);
        chk_rd("R1 desc0", cmd_a(0), 0);
        chk("R1 irq", 32'(irq), 0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < 32; i++) begin
            wr(cmd_a(i), OWNED);
            wr(hi_a(i), HI_INIT);
        end
        chk_rd("R10 desc7 cmd", cmd_a(7), OWNED);
        chk_rd("R10 desc7 hi", hi_a(7), HI_INIT);
    endtask

    task automatic t_disabled;
        frame(12'd100, 1'b0);
        chk_rd("R9 desc0 untouched", cmd_a(0), OWNED);
        chk_rd("R9 status", A_STAT, 0);
        chk_rd("R9 overflow", A_OVF, 0);
        wr(A_CTRL, 1);
        chk_rd("R10 control", A_CTRL, 1);
    endtask

    task automatic t_basic;
        frame(12'd64, 1'b0);
        chk_rd("R2 desc0 cmd", cmd_a(0), done_cmd(64));
        chk_rd("R3 desc0 hi no err", hi_a(0), 32'h0000_1234);
        chk_rd("R7 done set", A_STAT, 1);
        chk("R8 irq masked", 32'(irq), 0);
        wr(A_MASK, 0);
        chk_rd("R10 mask", A_MASK, 0);
        chk("R8 irq unmasked", 32'(irq), 1);
        wr(A_STAT, 0);
        chk_rd("R7 write 0 keeps", A_STAT, 1);
        wr(A_STAT, 1);
        chk_rd("R7 write 1 clears", A_STAT, 0);
        chk("R8 irq after clear", 32'(irq), 0);
    endtask

    task automatic t_error_max;
        frame(12'd2048, 1'b1);
        chk_rd("R2 desc1 max length", cmd_a(1), done_cmd(2048));
        chk_rd("R3 desc1 err bit", hi_a(1), HI_INIT);
        wr(A_STAT, 3);
    endtask

    task automatic t_not_owned;
        wr(cmd_a(2), 32'h0000_0800);
        frame(12'd100, 1'b0);
        chk_rd("R6 desc2 untouched", cmd_a(2), 32'h0000_0800);
        chk_rd("R6 overflow count", A_OVF, 1);
        chk_rd("R6 overflow status", A_STAT, 2);
        chk("R8 irq overflow", 32'(irq), 1);
        wr(A_STAT, 3);
        wr(cmd_a(2), OWNED);
        frame(12'd128, 1'b0);
        chk_rd("R6 pointer held at 2", cmd_a(2), done_cmd(128));
    endtask

    task automatic t_limit;
        wr(A_LIMIT, 4);
        chk_rd("R10 limit", A_LIMIT, 4);
        frame(12'd60, 1'b0);
        chk_rd("R5 desc3 below limit", cmd_a(3), done_cmd(60));
        frame(12'd61, 1'b0);
        chk_rd("R5 desc4 at limit untouched", cmd_a(4), OWNED);
        chk_rd("R5 overflow count", A_OVF, 2);
        wr(A_LIMIT, 32);
        frame(12'd62, 1'b0);
        chk_rd("R5 desc4 after raise", cmd_a(4), done_cmd(62));
    endtask

    task automatic t_wrap;
        for (int i = 5; i < 32; i++) frame(12'(200 + i), 1'(i % 2));
        chk_rd("R4 desc5 cmd", cmd_a(5), done_cmd(205));
        chk_rd("R3 desc5 hi err", hi_a(5), HI_INIT);
        chk_rd("R3 desc6 hi clean", hi_a(6), 32'h0000_1234);
        chk_rd("R4 desc31 cmd", cmd_a(31), done_cmd(231));
        frame(12'd300, 1'b0);
        chk_rd("R4 desc0 still host", cmd_a(0), done_cmd(64));
        chk_rd("R6 overflow after wrap", A_OVF, 3);
        wr(cmd_a(0), OWNED);
        frame(12'd511, 1'b0);
        chk_rd("R4 wrapped to desc0", cmd_a(0), done_cmd(511));
    endtask

    task automatic t_collision;
        wr(cmd_a(1), OWNED);
        wr(A_STAT, 3);
        chk_rd("R7 cleared before", A_STAT, 0);
        @(negedge clk);
        frm_done = 1'b1; frm_len = 12'd70; frm_err = 1'b0;
        host_addr = A_STAT; host_wdata = 1; host_wr = 1'b1;
        @(negedge clk);
        frm_done = 1'b0; host_wr = 1'b0;
        chk_rd("R7 set beats clear", A_STAT, 1);
        chk_rd("R2 desc1 collision", cmd_a(1), done_cmd(70));
    endtask

    task automatic t_reset_mid;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk_rd("R1 status after reset", A_STAT, 0);
        chk_rd("R1 overflow after reset", A_OVF, 0);
        chk_rd("R1 limit after reset", A_LIMIT, 32);
        chk_rd("R1 control after reset", A_CTRL, 0);
        chk_rd("R1 desc1 cleared", cmd_a(1), 0);
        wr(cmd_a(0), OWNED);
        wr(A_CTRL, 1);
        frame(12'd90, 1'b0);
        chk_rd("R1 pointer back at 0", cmd_a(0), done_cmd(90));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_disabled();
        t_basic();
        t_error_max();
        t_not_owned();
        t_limit();
        t_wrap();
        t_collision();
        t_reset_mid();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule